// File: doc/BRIEF.md
# Serial Character Transmitter with Break and Lead-In

This block sends serial characters, one bit per tick, on a single output line. Software-side logic writes a byte, together with an optional ninth bit, into a one-entry holding buffer. At the next character boundary the transmitter moves that entry into a shift register, framed by a low start bit and a high stop bit, and shifts it out least significant bit first. A bit-rate tick input, produced elsewhere, marks every bit time. A character written while another is being shifted follows it with no gap.

When the transmitter becomes active, it first sends one character time of idle-level ones. This lets the far end settle before the first start bit. While send-break is held, the line carries all-zero break characters back to back. The break length depends on the character length and on an extended-break mode. When the request is dropped, the break in progress finishes and one high bit follows it. The output can be inverted. An output-enable tells the pad whether the block drives the line.

Top module: `uart_brk_tx`

## Requirements
- R1: After reset the line is high (with invert off), `tx_empty` is 1, and `txd_oe` follows `blk_en`.
- R2: When `blk_en && tx_en` rises, the first tick starts a lead-in of ones. It lasts 10 bit times in 8-bit mode (`nine_bit`=0) and 11 in 9-bit mode (`nine_bit`=1). Data that is already held is sent only after the lead-in.
- R3: A character is sent LSB first, and each bit is held from one tick to the next. The order is: a 0 start bit, data bits 0..7, the ninth bit (9-bit mode only, taken from `bit8_in` at the buffer write), then a 1 stop bit. That makes 10 or 11 bit times.
- R4: A write clears `tx_empty`. The tick that moves the buffer into the shift register sets it again. `irq` equals `tx_empty && irq_en`.
- R5: A character held while another is shifting starts on the tick after that character's stop bit, with no idle bit between them. With nothing to send, the line idles high.
- R6: A break character holds the line low, with no start or stop bit. Its length is 10 bit times (8-bit), 11 (9-bit), 13 (8-bit, `lin_mode`=1) or 14 (9-bit, `lin_mode`=1).
- R7: At a boundary, a pending break request wins over held data, and breaks repeat while `brk_req` stays high. After the last break, exactly one high bit is sent before a held character's start bit.
- R8: `inv_out`=1 inverts the line at all times, including while idle, during characters and during breaks.
- R9: Dropping `blk_en` or `tx_en` returns the line to idle at the next clock and abandons the character being shifted. The held character and `tx_empty` are kept. `txd_oe` is low whenever `blk_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| blk_en | input | 1 | Block enable; also drives `txd_oe` |
| tx_en | input | 1 | Transmitter enable |
| nine_bit | input | 1 | 1 selects 9 data bits |
| bit8_in | input | 1 | Ninth data bit, captured on write |
| lin_mode | input | 1 | 1 selects the long break lengths |
| brk_req | input | 1 | Send break characters while high |
| inv_out | input | 1 | Invert the serial output |
| irq_en | input | 1 | Enable for the empty interrupt |
| wr_stb | input | 1 | Write strobe for the holding buffer |
| wr_data | input | DATA_W | Byte written to the holding buffer |
| txd | output | 1 | Serial output line |
| txd_oe | output | 1 | Output enable for the line |
| tx_empty | output | 1 | Holding buffer is empty |
| irq | output | 1 | Empty interrupt request |

## Verification
The hardest situation to reach is a boundary where a break request, a held character and the end of a break all meet. That boundary decides whether the single trailing high bit appears and whether the character waits behind it. The stimulus writes a character and raises the break request before the first tick, so the request has to win. It keeps the request high across one boundary, so a second break follows at once. It then drops the request in the middle of that second break. The line is checked bit by bit: zeros for exactly twice the break length, then one high bit, then the start bit. This is repeated for all four length settings. Abandoning a character mid-frame while another is held is reached by dropping `tx_en` between ticks, with the second write already made.

// File: rtl/uart_brk_pkg.sv
// Shared types for the serial transmitter.
// Assumes: used only by the uart_brk_* modules.
package uart_brk_pkg;

    // What the sequencer is currently shifting out.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_DATA,
        ST_BRK,
        ST_MARK
    } tx_state_e;

    // What the shift register loads at a character boundary.
    typedef enum logic [1:0] {
        LD_NONE,
        LD_ONES,
        LD_FRAME
    } load_e;

endpackage

// File: rtl/uart_brk_hold.sv
// One-entry holding buffer for a data byte and its ninth bit.
// Assumes: a write in the same cycle as a take leaves the buffer full
// with the new data, while the older data goes to the shift register.
module uart_brk_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              bit8_in,
    input  logic              take,
    output logic              hold_full,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_b8
);

    // Fill flag: a write sets it, and a take without a write clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_full <= 1'b0;
        end else begin
            hold_full <= wr_stb | (hold_full & ~take);
        end
    end

    // Capture the byte and the ninth bit together on every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_data <= '0;
            hold_b8   <= 1'b0;
        end else if (wr_stb) begin
            hold_data <= wr_data;
            hold_b8   <= bit8_in;
        end
    end

endmodule

// File: rtl/uart_brk_seq.sv
// Bit-time sequencer: counts the bits of the current item and, at each
// boundary, chooses the next item. The priority order is lead-in, break,
// trailing mark after a break, held data, then idle.
// Assumes: bit_tick is a one-cycle pulse, and an inactive transmitter
// drops straight back to idle.
module uart_brk_seq
    import uart_brk_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int LIN_EXTRA = 3,
    parameter int CNT_W     = $clog2(DATA_W + 3 + LIN_EXTRA + 1)
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  bit_tick,
    input  logic  active,
    input  logic  nine_bit,
    input  logic  lin_mode,
    input  logic  brk_req,
    input  logic  hold_full,
    output load_e ld_kind,
    output logic  take,
    output logic  shift_en,
    output logic  in_brk
);

    localparam int FRAME_SHORT = DATA_W + 2;
    localparam int FRAME_LONG  = DATA_W + 3;

    tx_state_e        state_q;
    tx_state_e        pick;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] pick_len;
    logic [CNT_W-1:0] frame_len;
    logic [CNT_W-1:0] brk_len;
    logic             act_q;
    logic             pre_pend;
    logic             busy;
    logic             boundary;

    // Item lengths in bit times for the current mode settings.
    always_comb begin
        frame_len = nine_bit ? CNT_W'(FRAME_LONG) : CNT_W'(FRAME_SHORT);
        brk_len   = lin_mode ? frame_len + CNT_W'(LIN_EXTRA) : frame_len;
    end

    // Boundary detection and the shift strobe.
    always_comb begin
        busy     = (state_q != ST_IDLE);
        boundary = bit_tick && active && (!busy || cnt_q == CNT_W'(1));
        shift_en = bit_tick && active && busy && !boundary;
        in_brk   = (state_q == ST_BRK);
    end

    // Choose the next item by priority.
    always_comb begin
        pick     = ST_IDLE;
        pick_len = '0;
        if (pre_pend) begin
            pick     = ST_PRE;
            pick_len = frame_len;
        end else if (brk_req) begin
            pick     = ST_BRK;
            pick_len = brk_len;
        end else if (state_q == ST_BRK) begin
            pick     = ST_MARK;
            pick_len = CNT_W'(1);
        end else if (hold_full) begin
            pick     = ST_DATA;
            pick_len = frame_len;
        end
    end

    // Tell the shift register and the buffer what happens at this boundary.
    always_comb begin
        take    = boundary && (pick == ST_DATA);
        ld_kind = LD_NONE;
        if (boundary) begin
            ld_kind = (pick == ST_DATA) ? LD_FRAME : LD_ONES;
        end
    end

    // Remember the previous enable level so a rising edge can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
        end else begin
            act_q <= active;
        end
    end

    // Lead-in request: raised when the transmitter turns on, cleared once the lead-in starts.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            pre_pend <= 1'b0;
        end else if (!act_q) begin
            pre_pend <= 1'b1;
        end else if (boundary && pick == ST_PRE) begin
            pre_pend <= 1'b0;
        end
    end

    // Current item and the number of bits it has left.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else if (boundary) begin
            state_q <= pick;
            cnt_q   <= pick_len;
        end else if (shift_en) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

endmodule

// File: rtl/uart_brk_shift.sv
// Shift register: loads a framed character or all ones and shifts right on
// each bit tick, filling with ones. Break bits are forced low at the output.
// Assumes: in 8-bit mode the unused top position holds a 1 that is never sent.
module uart_brk_shift
    import uart_brk_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  load_e             ld_kind,
    input  logic              shift_en,
    input  logic              in_brk,
    input  logic              nine_bit,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              hold_b8,
    output logic              txd_raw
);

    localparam int FW = DATA_W + 3;

    logic [FW-1:0] sreg;
    logic [FW-1:0] frame_word;

    // Frame layout: stop, optional ninth bit, data, start in the LSB.
    always_comb begin
        frame_word = {1'b1, (nine_bit ? hold_b8 : 1'b1), hold_data, 1'b0};
    end

    // Load at a boundary, otherwise shift towards the LSB.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            sreg <= '1;
        end else begin
            case (ld_kind)
                LD_FRAME: sreg <= frame_word;
                LD_ONES:  sreg <= '1;
                default: begin
                    if (shift_en) begin
                        sreg <= {1'b1, sreg[FW-1:1]};
                    end
                end
            endcase
        end
    end

    // Uninverted line level.
    always_comb begin
        txd_raw = in_brk ? 1'b0 : sreg[0];
    end

endmodule

// File: rtl/uart_brk_tx.sv
// Top of the serial transmitter: holding buffer, sequencer and shift register,
// plus output inversion, output enable and the empty interrupt.
// Assumes: bit_tick comes from an external bit-rate divider.
module uart_brk_tx
    import uart_brk_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int LIN_EXTRA = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              blk_en,
    input  logic              tx_en,
    input  logic              nine_bit,
    input  logic              bit8_in,
    input  logic              lin_mode,
    input  logic              brk_req,
    input  logic              inv_out,
    input  logic              irq_en,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              txd_oe,
    output logic              tx_empty,
    output logic              irq
);

    logic              active;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              hold_b8;
    logic              take;
    logic              shift_en;
    logic              in_brk;
    logic              txd_raw;
    load_e             ld_kind;

    // The transmitter runs only while both enables are set.
    always_comb begin
        active   = blk_en && tx_en;
        txd      = txd_raw ^ inv_out;
        txd_oe   = blk_en;
        tx_empty = !hold_full;
        irq      = tx_empty && irq_en;
    end

    uart_brk_hold #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .bit8_in   (bit8_in),
        .take      (take),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .hold_b8   (hold_b8)
    );

    uart_brk_seq #(.DATA_W(DATA_W), .LIN_EXTRA(LIN_EXTRA)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .active    (active),
        .nine_bit  (nine_bit),
        .lin_mode  (lin_mode),
        .brk_req   (brk_req),
        .hold_full (hold_full),
        .ld_kind   (ld_kind),
        .take      (take),
        .shift_en  (shift_en),
        .in_brk    (in_brk)
    );

    uart_brk_shift #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .ld_kind   (ld_kind),
        .shift_en  (shift_en),
        .in_brk    (in_brk),
        .nine_bit  (nine_bit),
        .hold_data (hold_data),
        .hold_b8   (hold_b8),
        .txd_raw   (txd_raw)
    );

endmodule

// File: rtl/uart_brk_tx_chk.sv
// Temporal checks on the transmitter, attached with bind.
module uart_brk_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic blk_en,
    input logic tx_en,
    input logic inv_out,
    input logic brk_req,
    input logic wr_stb,
    input logic txd,
    input logic tx_empty,
    input logic in_brk
);

    // R3: while the transmitter stays on, the line only moves after a tick.
    p_line_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_en && tx_en && $past(blk_en && tx_en) && !$past(bit_tick) && $stable(inv_out))
        |-> $stable(txd));

    // R4: a write always leaves the buffer full.
    p_write_clears_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !tx_empty);

    // R4: the empty flag only sets on a bit tick.
    p_empty_sets_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_empty) |-> $past(bit_tick));

    // R7: a break starts only when one was requested.
    p_break_needs_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_brk) |-> $past(brk_req));

    // R7: when a break ends, the line goes to the high level.
    p_mark_after_break_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_brk) && !in_brk && blk_en && tx_en && $past(blk_en && tx_en))
        |-> (txd != inv_out));

    // R9: after the transmitter turns off, the line is at the idle level.
    p_idle_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(blk_en && tx_en) |=> (txd == !inv_out));

endmodule

bind uart_brk_tx uart_brk_tx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick),
    .blk_en   (blk_en),
    .tx_en    (tx_en),
    .inv_out  (inv_out),
    .brk_req  (brk_req),
    .wr_stb   (wr_stb),
    .txd      (txd),
    .tx_empty (tx_empty),
    .in_brk   (in_brk)
);

// File: tb/uart_brk_tx_test.sv
`timescale 1ns/1ps
module uart_brk_tx_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       blk_en = 1'b0;
    logic       tx_en = 1'b0;
    logic       nine_bit = 1'b0;
    logic       bit8_in = 1'b0;
    logic       lin_mode = 1'b0;
    logic       brk_req = 1'b0;
    logic       inv_out = 1'b0;
    logic       irq_en = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       txd;
    logic       txd_oe;
    logic       tx_empty;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    uart_brk_tx uut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .blk_en(blk_en),
        .tx_en(tx_en), .nine_bit(nine_bit), .bit8_in(bit8_in),
        .lin_mode(lin_mode), .brk_req(brk_req), .inv_out(inv_out),
        .irq_en(irq_en), .wr_stb(wr_stb), .wr_data(wr_data),
        .txd(txd), .txd_oe(txd_oe), .tx_empty(tx_empty), .irq(irq)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One bit time: a tick pulse, then three idle clocks; sample afterwards.
    task automatic tick();
        @(negedge clk) bit_tick = 1'b1;
        @(negedge clk) bit_tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d, input logic b8);
        @(negedge clk) begin
            wr_stb  = 1'b1;
            wr_data = d;
            bit8_in = b8;
        end
        @(negedge clk) wr_stb = 1'b0;
    endtask

    // Expected level of frame bit i (0 = start bit).
    function automatic logic fbit(input logic [7:0] d, input logic b8,
                                  input logic nine, input int i);
        if (i == 0) return 1'b0;
        if (i <= 8) return d[i-1];
        if (nine && i == 9) return b8;
        return 1'b1;
    endfunction

    // Remaining bits of a frame whose start bit is already on the line.
    task automatic frame_rest(input logic [7:0] d, input logic b8, input logic nine,
                              input logic inv, input string req);
        for (int i = 1; i < (nine ? 11 : 10); i++) begin
            tick();
            check(req, "frame bit", txd, fbit(d, b8, nine, i) ^ inv);
        end
    endtask

    // Back-to-back characters; each next write is made during the previous start bit.
    task automatic run_stream(input int first, input int count, input int step,
                              input logic nine);
        int v;
        v = first % 512;
        wr(v[7:0], v[8]);
        for (int k = 0; k < count; k++) begin
            int nv;
            tick();
            check("R3", "start bit", txd, 1'b0);
            check("R4", "empty after load", tx_empty, 1'b1);
            nv = (first + (k + 1) * step) % 512;
            if (k + 1 < count) wr(nv[7:0], nv[8]);
            frame_rest(v[7:0], v[8], nine, 1'b0, "R5");
            v = nv;
        end
        tick();
        check("R5", "idle after stream", txd, 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "idle line", txd, 1'b1);
        check("R1", "empty", tx_empty, 1'b1);
        check("R1", "oe off", txd_oe, 1'b0);
        check("R4", "irq masked", irq, 1'b0);
        irq_en = 1'b1;
        @(negedge clk);
        check("R4", "irq when empty", irq, 1'b1);

        // Lead-in, 8-bit mode, with a character already held.
        blk_en = 1'b1;
        tx_en  = 1'b1;
        wr(8'hA5, 1'b0);
        check("R9", "oe on", txd_oe, 1'b1);
        check("R4", "write clears empty", tx_empty, 1'b0);
        check("R4", "irq drops", irq, 1'b0);
        for (int i = 0; i < 10; i++) begin
            tick();
            check("R2", "lead-in bit", txd, 1'b1);
        end
        check("R4", "still held after lead-in", tx_empty, 1'b0);
        tick();
        check("R2", "start after lead-in", txd, 1'b0);
        check("R4", "empty on load", tx_empty, 1'b1);
        check("R4", "irq on load", irq, 1'b1);
        frame_rest(8'hA5, 1'b0, 1'b0, 1'b0, "R3");
        tick();
        check("R5", "idle", txd, 1'b1);

        // Every byte value in 8-bit mode, then 9-bit mode with mixed ninth bits.
        run_stream(0, 256, 1, 1'b0);
        nine_bit = 1'b1;
        run_stream(5, 48, 37, 1'b1);

        // Breaks for all four length settings, with a character held behind them.
        for (int c = 0; c < 4; c++) begin
            int blen;
            nine_bit = c[0];
            lin_mode = c[1];
            blen = 10 + c[0] + (c[1] ? 3 : 0);
            @(negedge clk) brk_req = 1'b1;
            wr(8'h3C, 1'b1);
            for (int i = 0; i < 2 * blen; i++) begin
                tick();
                check("R6", "break bit low", txd, 1'b0);
                if (i == blen + 2) brk_req = 1'b0;
            end
            check("R7", "data held behind break", tx_empty, 1'b0);
            tick();
            check("R7", "mark after break", txd, 1'b1);
            tick();
            check("R7", "start after mark", txd, 1'b0);
            frame_rest(8'h3C, 1'b1, c[0], 1'b0, "R7");
            tick();
            check("R5", "idle after break test", txd, 1'b1);
        end
        nine_bit = 1'b0;
        lin_mode = 1'b0;

        // Inverted output: idle, a character and a break.
        @(negedge clk) inv_out = 1'b1;
        @(negedge clk);
        check("R8", "inverted idle", txd, 1'b0);
        wr(8'h96, 1'b0);
        tick();
        check("R8", "inverted start", txd, 1'b1);
        frame_rest(8'h96, 1'b0, 1'b0, 1'b1, "R8");
        @(negedge clk) brk_req = 1'b1;
        for (int i = 0; i < 10; i++) begin
            tick();
            check("R8", "inverted break", txd, 1'b1);
            brk_req = 1'b0;
        end
        tick();
        check("R8", "inverted mark", txd, 1'b0);
        @(negedge clk) inv_out = 1'b0;

        // Abandon a character mid-frame while another is held, then restart in 9-bit mode.
        wr(8'h11, 1'b0);
        tick();
        tick();
        tick();
        check("R3", "third bit of 0x11", txd, 1'b0);
        wr(8'h22, 1'b1);
        @(negedge clk) tx_en = 1'b0;
        @(negedge clk);
        check("R9", "idle when off", txd, 1'b1);
        check("R9", "held kept", tx_empty, 1'b0);
        @(negedge clk) blk_en = 1'b0;
        @(negedge clk);
        check("R9", "oe follows enable", txd_oe, 1'b0);
        nine_bit = 1'b1;
        blk_en   = 1'b1;
        tx_en    = 1'b1;
        for (int i = 0; i < 11; i++) begin
            tick();
            check("R2", "9-bit lead-in", txd, 1'b1);
        end
        tick();
        check("R2", "start after 9-bit lead-in", txd, 1'b0);
        frame_rest(8'h22, 1'b1, 1'b1, 1'b0, "R3");
        tick();
        check("R5", "final idle", txd, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule